// File: doc/BRIEF.md
# Serial Conversion-Result Output Port

This block is the output side of a sampling converter: it holds the most recent conversion result and hands it to a host that supplies its own serial clock. Each read is a 16-bit frame made of leading zero bits followed by the result, most significant bit first. There is no chip select. The port keeps its place in the frame only by counting serial clock edges. A falling edge on the conversion-start line brings it back to the start of a frame, but only when the serial clock is low at that moment.

All inputs are brought into the port's own clock domain through a synchronizer chain, and edges are detected there. The serial clock must therefore be slow compared with `clk`. Any output change follows the serial clock or conversion-start edge that causes it within `SYNC_STAGES + 2` cycles of `clk`. The data pin is shown as a value plus an output-enable, so the pad driver sits outside the block. The result coding is set by a parameter. The converter delivers offset binary, with 0 for the lowest input. The port can pass this through as straight binary or turn it into two's complement.

Top module: `sadc_outport`

## Requirements
- R1: A frame carries 16 bits on `sdata`: two zero bits first, then result bits 13 down to 0.
- R2: The first frame bit appears after the first rising edge of `sclk`. Each later bit appears after a falling edge. A rising edge inside a frame never changes `sdata`.
- R3: On the 16th falling edge of `sclk`, `sdata_oe` goes low. The frame position never passes 16.
- R4: A rising edge of `sclk` while the port is not driving starts a new frame from the same held result. `sdata_oe` goes high and the first leading zero is shown.
- R5: A falling edge of `conv_start_n` while `sclk` is low returns the port to the idle state with `sdata_oe` low. The next rising edge starts a complete frame from bit 0.
- R6: A falling edge of `conv_start_n` while `sclk` is high has no effect on the frame position or the output.
- R7: The port does not lose its place when `sclk` pauses in the middle of a frame for any length of time.
- R8: A one-cycle `result_load` pulse captures `result_in` into the held result. Every frame started after the capture sends that value.
- R9: With `TWOS_COMP` = 1, the most significant bit of the 14-bit offset-binary input is inverted, giving two's complement. With `TWOS_COMP` = 0, the input is sent unchanged as straight binary.
- R10: `sdata` is 0 whenever `sdata_oe` is 0. After reset, the port is idle with `sdata_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, used to sample all other inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock from the host |
| conv_start_n | input | 1 | Conversion start; its falling edge can re-align the frame |
| result_load | input | 1 | One-cycle strobe at the end of a conversion |
| result_in | input | 14 | Offset-binary conversion result |
| sdata | output | 1 | Serial data value |
| sdata_oe | output | 1 | High while `sdata` should be driven onto the pin |

## Verification
The bench builds two copies side by side, one with `TWOS_COMP` = 1 and one with `TWOS_COMP` = 0. Both use `SYNC_STAGES` = 2 and share every input. This lets each frame check both codings on the same stimulus, including the codes where the most significant bit flips. The serial clock half-period is eight port cycles, which is well above the synchronizer and state latency. That margin lets the bench place conversion-start edges cleanly inside the high or the low `sclk` phase, and it lets the bench hold a pause inside a frame.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_DONE  = 2'd2
  } fr_state_e;

  // True when the given position is the last bit slot of a frame.
  function automatic logic is_last_slot(input int unsigned pos, input int unsigned frame_bits);
    return pos == frame_bits - 1;
  endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int        WIDTH   = 2,
  parameter int        STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [WIDTH-1:0] chain [STAGES];
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            chain[g] <= RST_VAL;
          end else if (g == 0) begin
            chain[g] <= din;
          end else begin
            chain[g] <= chain[(g > 0) ? g - 1 : 0];
          end
        end
      end
      assign dout = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sadc_edges.sv
module sadc_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic conv_n_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic conv_fall,
  output logic sclk_level
);

  logic sclk_d;
  logic conv_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      conv_n_d <= 1'b1;
    end else begin
      sclk_d   <= sclk_s;
      conv_n_d <= conv_n_s;
    end
  end

  assign sclk_rise  = sclk_s & ~sclk_d;
  assign sclk_fall  = ~sclk_s & sclk_d;
  assign conv_fall  = ~conv_n_s & conv_n_d;
  assign sclk_level = sclk_d;

endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
  import sadc_pkg::*;
#(
  parameter int RES_BITS   = 14,
  parameter int LEAD_ZEROS = 2,
  parameter bit TWOS_COMP  = 1'b1,
  localparam int FRAME_BITS = RES_BITS + LEAD_ZEROS,
  localparam int POS_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_rise,
  input  logic                ev_fall,
  input  logic                ev_clear,
  input  logic                load,
  input  logic [RES_BITS-1:0] result_in,
  output logic                sdata,
  output logic                sdata_oe,
  output logic                frame_end,
  output logic [POS_W-1:0]    frame_pos
);

  // Offset binary in; optional MSB inversion gives two's complement.
  function automatic logic [RES_BITS-1:0] format_code(input logic [RES_BITS-1:0] raw);
    logic [RES_BITS-1:0] r;
    r = raw;
    if (TWOS_COMP) r[RES_BITS-1] = ~raw[RES_BITS-1];
    return r;
  endfunction

  fr_state_e             state_q;
  logic [RES_BITS-1:0]   hold_q;
  logic [FRAME_BITS-1:0] shreg_q;
  logic [POS_W-1:0]      pos_q;
  logic                  last_slot;

  assign last_slot = is_last_slot(int'(pos_q), FRAME_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (load) begin
      hold_q <= format_code(result_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      shreg_q <= '0;
      pos_q   <= '0;
    end else if (ev_clear) begin
      state_q <= FR_IDLE;
      pos_q   <= '0;
    end else begin
      unique case (state_q)
        FR_IDLE, FR_DONE: begin
          if (ev_rise) begin
            shreg_q <= FRAME_BITS'(hold_q);
            pos_q   <= '0;
            state_q <= FR_SHIFT;
          end
        end
        FR_SHIFT: begin
          if (ev_fall) begin
            if (last_slot) begin
              pos_q   <= POS_W'(FRAME_BITS);
              state_q <= FR_DONE;
            end else begin
              shreg_q <= shreg_q << 1;
              pos_q   <= pos_q + 1'b1;
            end
          end
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end

  assign sdata_oe  = (state_q == FR_SHIFT);
  assign sdata     = sdata_oe & shreg_q[FRAME_BITS-1];
  assign frame_end = (state_q == FR_SHIFT) & ev_fall & last_slot & ~ev_clear;
  assign frame_pos = pos_q;

endmodule

// File: rtl/sadc_outport.sv
module sadc_outport #(
  parameter int RES_BITS    = 14,
  parameter int LEAD_ZEROS  = 2,
  parameter bit TWOS_COMP   = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                conv_start_n,
  input  logic                result_load,
  input  logic [RES_BITS-1:0] result_in,
  output logic                sdata,
  output logic                sdata_oe
);

  localparam int FRAME_BITS = RES_BITS + LEAD_ZEROS;
  localparam int POS_W      = $clog2(FRAME_BITS + 1);

  logic [1:0]       pins_s;
  logic             ev_rise;
  logic             ev_fall;
  logic             conv_fall;
  logic             sclk_level;
  logic             ev_clear;
  logic             ev_frame_end;
  logic [POS_W-1:0] frame_pos;

  sadc_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b10)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({conv_start_n, sclk}),
    .dout (pins_s)
  );

  sadc_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[0]),
    .conv_n_s  (pins_s[1]),
    .sclk_rise (ev_rise),
    .sclk_fall (ev_fall),
    .conv_fall (conv_fall),
    .sclk_level(sclk_level)
  );

  // Re-alignment only counts when the serial clock sits low.
  assign ev_clear = conv_fall & ~sclk_level & ~ev_rise;

  sadc_frame #(
    .RES_BITS  (RES_BITS),
    .LEAD_ZEROS(LEAD_ZEROS),
    .TWOS_COMP (TWOS_COMP)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .ev_clear (ev_clear),
    .load     (result_load),
    .result_in(result_in),
    .sdata    (sdata),
    .sdata_oe (sdata_oe),
    .frame_end(ev_frame_end),
    .frame_pos(frame_pos)
  );

endmodule

// File: rtl/sadc_outport_chk.sv
module sadc_outport_chk #(
  parameter int FRAME_BITS = 16,
  parameter int LEAD_ZEROS = 2,
  parameter int POS_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sdata,
  input logic             sdata_oe,
  input logic             ev_rise,
  input logic             ev_fall,
  input logic             ev_clear,
  input logic             ev_frame_end,
  input logic [POS_W-1:0] frame_pos
);

  assert_oe_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_end |=> !sdata_oe);

  assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pos <= POS_W'(FRAME_BITS));

  assert_quiet_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata);

  assert_clear_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> (!sdata_oe && frame_pos == '0));

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdata_oe && ev_rise && !ev_clear) |=> (sdata_oe && (LEAD_ZEROS == 0 || !sdata)));

  assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rise && !ev_fall && !ev_clear) |=> ($stable(sdata) && $stable(sdata_oe)));

  assert_rise_keeps_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && ev_rise && !ev_clear) |=> $stable(sdata));

endmodule

bind sadc_outport sadc_outport_chk #(
  .FRAME_BITS(FRAME_BITS),
  .LEAD_ZEROS(LEAD_ZEROS),
  .POS_W     (POS_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sdata       (sdata),
  .sdata_oe    (sdata_oe),
  .ev_rise     (ev_rise),
  .ev_fall     (ev_fall),
  .ev_clear    (ev_clear),
  .ev_frame_end(ev_frame_end),
  .frame_pos   (frame_pos)
);

// File: tb/test_sadc_outport.sv
module test_sadc_outport;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        conv_start_n = 1'b1;
  logic        result_load = 1'b0;
  logic [13:0] result_in = '0;
  logic        sdata, sdata_oe, sdata_u, sdata_oe_u;

  int n_tests = 0;
  int n_fail  = 0;
  int rise_mism = 0;

  always #5 clk = ~clk;

  sadc_outport #(.TWOS_COMP(1'b1), .SYNC_STAGES(2)) i_sadc_outport (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .conv_start_n(conv_start_n),
    .result_load(result_load), .result_in(result_in),
    .sdata(sdata), .sdata_oe(sdata_oe)
  );

  sadc_outport #(.TWOS_COMP(1'b0), .SYNC_STAGES(2)) i_sadc_outport_ub (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .conv_start_n(conv_start_n),
    .result_load(result_load), .result_in(result_in),
    .sdata(sdata_u), .sdata_oe(sdata_oe_u)
  );

  // {offset-binary input, expected two's-complement frame}
  localparam logic [29:0] VEC [6] = '{
    {14'h0000, 16'h2000},
    {14'h3FFF, 16'h1FFF},
    {14'h2000, 16'h0000},
    {14'h1555, 16'h3555},
    {14'h2AAA, 16'h0AAA},
    {14'h0001, 16'h2001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic last_low;
  logic have_low = 1'b0;

  task automatic pulse(output logic b, output logic bu, output logic oe);
    sclk = 1'b1;
    wait_clk(8);
    b = sdata; bu = sdata_u; oe = sdata_oe;
    if (have_low && oe && b !== last_low) rise_mism++;
    sclk = 1'b0;
    wait_clk(8);
    last_low = sdata; have_low = 1'b1;
  endtask

  task automatic read_bits(input int n, inout logic [15:0] f, inout logic [15:0] fu,
                           output logic first_oe);
    logic b, bu, oe;
    for (int i = 0; i < n; i++) begin
      pulse(b, bu, oe);
      if (i == 0) first_oe = oe;
      f  = {f[14:0], b};
      fu = {fu[14:0], bu};
    end
  endtask

  task automatic conv_pulse();
    conv_start_n = 1'b0;
    wait_clk(8);
    conv_start_n = 1'b1;
    wait_clk(8);
    have_low = 1'b0;
  endtask

  task automatic load_word(input logic [13:0] w);
    result_in = w;
    result_load = 1'b1;
    wait_clk(1);
    result_load = 1'b0;
    wait_clk(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("[TB] FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] f, fu;
    logic oe0, b, bu, oe;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);

    // R10: idle after reset
    check("R10 reset oe", 32'(sdata_oe), 32'd0);
    check("R10 reset data", 32'(sdata), 32'd0);

    // R1 R8 R9 R3: table of results
    for (int v = 0; v < 6; v++) begin
      conv_pulse();
      load_word(VEC[v][29:16]);
      f = '0; fu = '0;
      read_bits(16, f, fu, oe0);
      check("R1 R9 two's complement frame", 32'(f), 32'(VEC[v][15:0]));
      check("R9 straight binary frame", 32'(fu), {18'd0, VEC[v][29:16]});
      check("R3 oe low after 16th fall", 32'(sdata_oe), 32'd0);
    end
    check("R2 rising edge keeps bit", 32'(rise_mism), 32'd0);

    // R4: extra pulses restart with the held word
    f = '0; fu = '0;
    read_bits(16, f, fu, oe0);
    check("R4 restart drives oe", 32'(oe0), 32'd1);
    check("R4 restart frame", 32'(f), 32'h2001);

    // R5: conversion start with sclk low realigns
    load_word(14'h2AAA);
    conv_pulse();
    f = '0; fu = '0;
    read_bits(5, f, fu, oe0);
    conv_pulse();
    check("R5 clear drops oe", 32'(sdata_oe), 32'd0);
    f = '0; fu = '0;
    read_bits(16, f, fu, oe0);
    check("R5 full frame after clear", 32'(f), 32'h0AAA);

    // R6: conversion start with sclk high ignored
    load_word(14'h1555);
    conv_pulse();
    f = '0; fu = '0;
    read_bits(5, f, fu, oe0);
    sclk = 1'b1;
    wait_clk(8);
    b = sdata;
    conv_start_n = 1'b0;
    wait_clk(8);
    conv_start_n = 1'b1;
    wait_clk(8);
    check("R6 oe kept while sclk high", 32'(sdata_oe), 32'd1);
    sclk = 1'b0;
    wait_clk(8);
    have_low = 1'b0;
    f = {f[14:0], b};
    read_bits(10, f, fu, oe0);
    check("R6 position kept", 32'(f), 32'h3555);

    // R7: pause in the middle of a frame
    load_word(14'h3FFF);
    conv_pulse();
    f = '0; fu = '0;
    read_bits(8, f, fu, oe0);
    wait_clk(300);
    have_low = 1'b0;
    read_bits(8, f, fu, oe0);
    check("R7 frame across pause", 32'(f), 32'h1FFF);

    // R8: load mid-idle affects only later frames
    conv_pulse();
    load_word(14'h0000);
    pulse(b, bu, oe);
    check("R2 first bit is a leading zero", {30'd0, oe, b}, 32'd2);
    check("R10 unused-mode quiet", 32'(sdata_oe_u), 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule